// File: doc/BRIEF.md
# Serial Memory Slave Engine

This block is the bus-facing engine of an 8192-byte serial memory on a two-wire I2C bus. The clock and data lines are sampled with the system clock through two-flop synchronisers. The engine detects START and STOP conditions and matches the device byte against three strap inputs. For a write it receives a two-byte memory address and hands each data byte to a separate page write unit. For a read it shifts bytes out of a combinational memory read port. The data line is driven through an open-drain enable: when the enable is high the line is pulled low.

The engine keeps one persistent address counter. Current-address reads, selective reads and sequential reads all use this counter. A selective read is a write-mode address phase followed by a repeated START. While the page write unit reports an internal write in progress, the engine does not acknowledge its own address, so a master can poll until the write is done. A STOP that ends a write carrying data produces a commit pulse, which starts the internal write cycle.

Top module: `serial_mem_slave`

## Requirements
- R1: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. Without a START the engine never acknowledges, and a STOP always returns it to idle.
- R2: The device byte is matched as follows. Bits 7..4 must be 1010. Bits 3..1 must equal the strap pins. Bit 0 selects read (1) or write (0). On a match the engine pulls the data line low during the 9th clock.
- R3: After a device byte that does not match, the engine gives no acknowledge and keeps the data line released until the next START.
- R4: While `wr_busy_i` is high, the engine does not acknowledge a device byte, even one that matches, for either read or write.
- R5: In write mode the engine acknowledges both address bytes and every data byte. Each data byte appears on the write port for one cycle with its address, and successive bytes go to successive addresses.
- R6: The memory address is sent high byte first. The top three bits of the high byte are ignored, which leaves a 13-bit address.
- R7: Read data goes out MSB first. The data line changes only while the clock line is low. A 0 is sent by pulling the line low and a 1 by releasing it. The engine releases the line during the 9th clock of each read byte.
- R8: If the master pulls the line low in the 9th clock of a read byte, the engine sends the next byte. On a NoACK the engine stops driving.
- R9: The address counter points one past the last byte read or written. A read that starts without an address phase begins at the counter.
- R10: The address counter wraps from byte 8191 to byte 0.
- R11: A write-mode address phase followed by a repeated START and a read-mode device byte loads the counter, and the read starts at the loaded address.
- R12: A STOP that ends a write which carried at least one data byte produces a one-cycle `wr_commit_o` pulse. A write that ends after its address phase produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| strap_i | input | 3 | Device select straps compared with bits 3..1 of the device byte |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 13 | Memory address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse that starts the internal write |
| rd_addr_o | output | 13 | Address counter, used as the read port address |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, combinational |

## Verification
The bench targets the counter at the top of memory. A sequential read over byte 8191 must return byte 0 next, and the following current-address read must start at byte 1. A counter that saturates, or that skips its post-increment, returns the wrong byte. The bench also checks that a dummy write which ends in a repeated START emits no write strobe and no commit pulse; a design that treated the START as a STOP would start a spurious write. After a NoACK it clocks a further byte to show that the line stays released, since an engine that ignored the NoACK would keep pulling the line low. It also sends a matching address while the write is busy, and a wrong strap value, to show that neither gets an acknowledge.

// File: rtl/sms_pkg.sv
// Package: shared types of the serial memory slave engine.
// Assumes: one engine per bus; the state codes are only used internally.
package sms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a START
        ST_DEV,    // receiving the device byte
        ST_AHI,    // receiving the address high byte
        ST_ALO,    // receiving the address low byte
        ST_WDAT,   // receiving write data
        ST_RDAT    // sending read data
    } sms_state_e;
endpackage

// File: rtl/sms_line_sync.sv
// Module: two-flop synchroniser for N bus lines, plus a third stage that
// holds the previous synchronised value for edge detection.
// Assumes: the lines idle high (pull-ups), so every stage resets to 1.
module sms_line_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    localparam int STAGES = 3;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Purpose: shift the raw line through the synchroniser stages.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw_i[g]};
        end
        assign cur_o[g]  = pipe[STAGES-2];
        assign prev_o[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/sms_bus_cond.sv
// Module: decodes clock edges and START/STOP conditions from the current and
// previous synchronised line values.
// Assumes: the inputs come from the same synchroniser, so they are aligned.
module sms_bus_cond (
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Purpose: classify the clock edges and the data edges that occur while the clock is high.
    always_comb begin
        scl_rise  = scl_cur & ~scl_prev;
        scl_fall  = ~scl_cur & scl_prev;
        start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
        stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
    end
endmodule

// File: rtl/sms_addr_ctr.sv
// Module: persistent memory address counter with load and post-increment.
// Assumes: the memory size is 2**W, so the counter wraps naturally at its top.
module sms_addr_ctr #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    // Purpose: a load takes priority; otherwise advance by one on each access.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= load_val_i;
        else if (inc_i)  q_o <= q_o + 1'b1;
    end
endmodule

// File: rtl/serial_mem_slave.sv
// Module: two-wire serial memory slave engine. It receives the device byte,
// the address and the write data; it shifts out read data and keeps the
// shared address counter.
// Assumes: the bus clock runs well below clk/8; rd_data_i is combinational
// from rd_addr_o; wr_busy_i comes from the page write unit.
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int                ADDR_W   = 13,
    parameter int                SEL_W    = 3,
    parameter logic [6-SEL_W:0]  DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [SEL_W-1:0]  strap_i,
    input  logic              wr_busy_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int BIT_W = 4;
    localparam logic [BIT_W-1:0] ACK_SLOT = 4'd8;
    localparam logic [BIT_W-1:0] ACK_END  = 4'd9;

    logic [1:0] sync_cur, sync_prev;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    sms_state_e         state;
    logic [BIT_W-1:0]   bitcnt;
    logic [7:0]         shreg;
    logic [HI_W-1:0]    hi_q;
    logic               dev_rd, m_ack, got_data;
    logic               dev_match, byte_done, ack_end;
    logic               ctr_load, ctr_inc;

    sms_line_sync #(.N(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    assign scl_s = sync_cur[0];
    assign sda_s = sync_cur[1];

    sms_bus_cond u_cond (
        .scl_cur   (sync_cur[0]),
        .scl_prev  (sync_prev[0]),
        .sda_cur   (sync_cur[1]),
        .sda_prev  (sync_prev[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Purpose: decode byte boundaries and the counter controls.
    always_comb begin
        dev_match = (shreg[7:SEL_W+1] == DEV_CODE) && (shreg[SEL_W:1] == strap_i) && !wr_busy_i;
        byte_done = scl_fall && (bitcnt == ACK_SLOT) && (state != ST_IDLE) && (state != ST_RDAT);
        ack_end   = scl_fall && (bitcnt == ACK_END) && (state != ST_IDLE);
        ctr_load  = !start_det && !stop_det && byte_done && (state == ST_ALO);
        ctr_inc   = !start_det && !stop_det &&
                    ((byte_done && (state == ST_WDAT)) ||
                     (ack_end && (((state == ST_DEV) && dev_rd) || ((state == ST_RDAT) && m_ack))));
    end

    sms_addr_ctr #(.W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i ({hi_q, shreg}),
        .inc_i      (ctr_inc),
        .q_o        (rd_addr_o)
    );

    // Purpose: bus state machine covering bit counting, acknowledge, data shifting and the write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            hi_q        <= '0;
            dev_rd      <= 1'b0;
            m_ack       <= 1'b0;
            got_data    <= 1'b0;
            sda_oe_o    <= 1'b0;
            wr_valid_o  <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_commit_o <= 1'b0;
        end else begin
            wr_valid_o  <= 1'b0;
            wr_commit_o <= 1'b0;
            if (stop_det) begin
                wr_commit_o <= (state == ST_WDAT) && got_data;
                state       <= ST_IDLE;
                bitcnt      <= '0;
                sda_oe_o    <= 1'b0;
            end else if (start_det) begin
                state    <= ST_DEV;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
                got_data <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < ACK_SLOT && state != ST_RDAT) shreg <= {shreg[6:0], sda_s};
                    if (bitcnt == ACK_SLOT && state == ST_RDAT) m_ack <= ~sda_s;
                    if (bitcnt != ACK_END) bitcnt <= bitcnt + 1'b1;
                end
                if (scl_fall) begin
                    if (bitcnt == ACK_SLOT) begin
                        if (state == ST_RDAT) begin
                            sda_oe_o <= 1'b0;
                        end else begin
                            unique case (state)
                                ST_DEV: begin
                                    if (dev_match) begin
                                        sda_oe_o <= 1'b1;
                                        dev_rd   <= shreg[0];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_AHI: begin
                                    sda_oe_o <= 1'b1;
                                    hi_q     <= shreg[HI_W-1:0];
                                end
                                ST_ALO: sda_oe_o <= 1'b1;
                                ST_WDAT: begin
                                    sda_oe_o   <= 1'b1;
                                    wr_valid_o <= 1'b1;
                                    wr_addr_o  <= rd_addr_o;
                                    wr_data_o  <= shreg;
                                    got_data   <= 1'b1;
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end else if (bitcnt == ACK_END) begin
                        bitcnt   <= '0;
                        sda_oe_o <= 1'b0;
                        unique case (state)
                            ST_DEV: begin
                                if (dev_rd) begin
                                    state    <= ST_RDAT;
                                    shreg    <= rd_data_i;
                                    sda_oe_o <= ~rd_data_i[7];
                                end else begin
                                    state <= ST_AHI;
                                end
                            end
                            ST_AHI:  state <= ST_ALO;
                            ST_ALO:  state <= ST_WDAT;
                            ST_WDAT: state <= ST_WDAT;
                            ST_RDAT: begin
                                if (m_ack) begin
                                    shreg    <= rd_data_i;
                                    sda_oe_o <= ~rd_data_i[7];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end else if (state == ST_RDAT && bitcnt != '0) begin
                        sda_oe_o <= ~shreg[3'd7 - bitcnt[2:0]];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_mem_slave_chk.sv
// Module: property checker for serial_mem_slave, attached with bind.
// Assumes: it observes the engine's own state and synchronised clock level.
module serial_mem_slave_chk
    import sms_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input sms_state_e        state,
    input logic [3:0]        bitcnt,
    input logic              scl_fall,
    input logic              scl_lvl,
    input logic              stop_det,
    input logic              ctr_inc,
    input logic              ctr_load,
    input logic              sda_oe_o,
    input logic              wr_valid_o,
    input logic              wr_commit_o,
    input logic              wr_busy_i,
    input logic [ADDR_W-1:0] rd_addr_o
);
    // R1, R3: an idle engine never pulls the data line low
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R4: no acknowledge for a device byte while the write is busy
    p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && bitcnt == 4'd8 && scl_fall && wr_busy_i) |=> !sda_oe_o);

    // R5: every strobed data byte is acknowledged at the same time
    p_wr_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> sda_oe_o);

    // R7: the data drive changes only while the clock line is low
    p_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl));

    // R10: the counter wraps to zero after its top value
    p_ctr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && !ctr_load && rd_addr_o == {ADDR_W{1'b1}}) |=> (rd_addr_o == '0));

    // R12: a commit pulse follows a STOP
    p_commit_on_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_det));
endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .bitcnt      (bitcnt),
    .scl_fall    (scl_fall),
    .scl_lvl     (scl_s),
    .stop_det    (stop_det),
    .ctr_inc     (ctr_inc),
    .ctr_load    (ctr_load),
    .sda_oe_o    (sda_oe_o),
    .wr_valid_o  (wr_valid_o),
    .wr_commit_o (wr_commit_o),
    .wr_busy_i   (wr_busy_i),
    .rd_addr_o   (rd_addr_o)
);

// File: tb/serial_mem_slave_tb_top.sv
// Directed bench: a bit-level bus master, a computed memory image and one task per scenario.
module serial_mem_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wr_busy = 1'b0;
    logic        sda_oe, wr_valid, wr_commit;
    logic [12:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        sda_line;
    int          n_chk = 0, n_fail = 0;
    int          wn = 0, cn = 0;
    logic [12:0] wlog_a [8];
    logic [7:0]  wlog_d [8];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [7:0] mem_byte(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    assign rd_data = mem_byte(rd_addr);

    serial_mem_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (3'b101),
        .wr_busy_i   (wr_busy),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    // Record the write strobes and commit pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (wn < 8) begin
                wlog_a[wn] = wr_addr;
                wlog_d[wn] = wr_data;
            end
            wn++;
        end
        if (rst_n && wr_commit) cn++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic b, output logic s);
        scl_m = 1'b0; wait_c(10);
        sda_m = b;    wait_c(10);
        scl_m = 1'b1; wait_c(10);
        s = sda_line; wait_c(10);
    endtask

    task automatic do_start();
        scl_m = 1'b0; wait_c(10);
        sda_m = 1'b1; wait_c(10);
        scl_m = 1'b1; wait_c(10);
        sda_m = 1'b0; wait_c(10);
    endtask

    task automatic do_stop();
        scl_m = 1'b0; wait_c(10);
        sda_m = 1'b0; wait_c(10);
        scl_m = 1'b1; wait_c(10);
        sda_m = 1'b1; wait_c(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic ninth);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(~give_ack, s);
        ninth = s;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 reset drive", sda_oe, 0);
        chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R1 reset strobes", {wr_valid, wr_commit}, 0);
        chk(rd_addr == 13'h0, "R9 reset counter", rd_addr, 0);
    endtask

    task automatic t_no_start();
        logic a;
        send_byte(8'hAA, a);
        chk(a == 1'b0, "R1 no ack without START", a, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        do_start();
        send_byte(8'hA0, a);
        chk(a == 1'b0, "R3 wrong strap gets no ack", a, 0);
        send_byte(8'h00, a);
        chk(a == 1'b0, "R3 stays released", a, 0);
        do_stop();
    endtask

    task automatic t_write();
        logic a;
        do_start();
        send_byte(8'hAA, a);
        chk(a == 1'b1, "R2 write device ack", a, 1);
        send_byte(8'hE1, a);
        chk(a == 1'b1, "R5 high address ack", a, 1);
        send_byte(8'h23, a);
        chk(a == 1'b1, "R5 low address ack", a, 1);
        send_byte(8'h5A, a);
        chk(a == 1'b1, "R5 data ack 0", a, 1);
        send_byte(8'h77, a);
        chk(a == 1'b1, "R5 data ack 1", a, 1);
        do_stop();
        wait_c(10);
        chk(wn == 2, "R5 strobe count", wn, 2);
        chk(wlog_a[0] == 13'h0123, "R6 top bits ignored", wlog_a[0], 13'h0123);
        chk(wlog_d[0] == 8'h5A, "R5 first data", wlog_d[0], 8'h5A);
        chk(wlog_a[1] == 13'h0124 && wlog_d[1] == 8'h77, "R5 next address", {wlog_a[1], wlog_d[1]}, {13'h0124, 8'h77});
        chk(cn == 1, "R12 commit after data", cn, 1);
    endtask

    task automatic t_busy();
        logic a;
        wr_busy = 1'b1;
        do_start();
        send_byte(8'hAB, a);
        chk(a == 1'b0, "R4 busy read poll", a, 0);
        do_start();
        send_byte(8'hAA, a);
        chk(a == 1'b0, "R4 busy write poll", a, 0);
        do_stop();
        wr_busy = 1'b0;
    endtask

    task automatic t_cur_read();
        logic a, n9;
        logic [7:0] b;
        do_start();
        send_byte(8'hAB, a);
        chk(a == 1'b1, "R2 read device ack", a, 1);
        recv_byte(1'b0, b, n9);
        chk(b == mem_byte(13'h0125), "R9 current address read", b, mem_byte(13'h0125));
        chk(n9 == 1'b1, "R7 released in 9th clock", n9, 1);
        do_stop();
    endtask

    task automatic t_sel_seq();
        logic a, n9;
        logic [7:0] b;
        do_start();
        send_byte(8'hAA, a);
        send_byte(8'h1F, a);
        send_byte(8'hFE, a);
        chk(a == 1'b1, "R11 dummy address ack", a, 1);
        do_start();
        send_byte(8'hAB, a);
        chk(a == 1'b1, "R11 repeated START read ack", a, 1);
        recv_byte(1'b1, b, n9);
        chk(b == mem_byte(13'h1FFE), "R11 selective read", b, mem_byte(13'h1FFE));
        recv_byte(1'b1, b, n9);
        chk(b == mem_byte(13'h1FFF), "R8 sequential next", b, mem_byte(13'h1FFF));
        recv_byte(1'b0, b, n9);
        chk(b == mem_byte(13'h0000), "R10 wrap to zero", b, mem_byte(13'h0000));
        recv_byte(1'b0, b, n9);
        chk(b == 8'hFF, "R8 silent after NoACK", b, 8'hFF);
        do_stop();
        wait_c(10);
        chk(wn == 2 && cn == 1, "R12 dummy write no commit", {wn, cn}, {32'd2, 32'd1});
    endtask

    task automatic t_after_wrap();
        logic a, n9;
        logic [7:0] b;
        do_start();
        send_byte(8'hAB, a);
        recv_byte(1'b0, b, n9);
        chk(b == mem_byte(13'h0001), "R9 one past last read", b, mem_byte(13'h0001));
        do_stop();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        wait_c(5);
        t_reset();
        rst_n = 1'b1;
        wait_c(5);
        t_no_start();
        t_mismatch();
        t_write();
        t_busy();
        t_cur_read();
        t_sel_seq();
        t_after_wrap();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule